// File: doc/BRIEF.md
# Multi-Mode Serial Response Compactor

This block reduces a long single-bit response stream, as produced by a circuit under self-test, to a short signature. One datapath offers four compaction methods. A mode code picks the method at run time: a count of ones, a count of value changes between consecutive bits, a running odd/even parity, or a 3-bit serial-input linear feedback shift register (LFSR) signature.

A start pulse clears every accumulator and latches the mode. After that, each response bit that arrives with its valid strobe high is folded into the signature. Alongside the signature the block keeps a count of the valid bits it has accepted. When the stimulus is an exhaustive sweep of all 2^n input combinations, the ones count divided by that vector count is the syndrome of the circuit. Software forms that ratio; the block does not divide.

Both counters saturate instead of wrapping. A sticky flag records that a count was lost.

Top module: `resp_compactor`

## Requirements
- R1: After reset the block has signature 0, vec_count 0, ready 0 and overflow 0. Valid bits that arrive before the first start pulse are ignored.
- R2: A start pulse clears the signature, vec_count and overflow, latches mode_sel, and sets ready one cycle later. A bit that is valid in the same cycle as start is dropped.
- R3: With latched mode code 0 (ones), the signature is the number of accepted bits equal to 1.
- R4: With latched mode code 1 (transitions), the signature counts accepted bits that differ from the previous accepted bit. Rising and falling changes both count. The first bit after start has no predecessor and never counts.
- R5: With latched mode code 2 (parity), signature bit 0 is 1 when the number of accepted ones is odd and 0 when it is even. All higher bits are 0.
- R6: With latched mode code 3 (signature register), a 3-bit state s starts at 0. Each accepted bit b moves it to {s[1:0], s[2]^s[1]^b}. The signature is s in bits 2:0, with all higher bits 0.
- R7: vec_count counts every accepted bit in all four modes.
- R8: vec_count and the mode counter stop at 2^CNT_W-1. An increment that arrives at that maximum sets overflow. Overflow stays set until the next start or reset.
- R9: Changes on mode_sel between start pulses have no effect on the running compaction.
- R10: Cycles with bit_valid low leave the signature and vec_count unchanged, whatever bit_in is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Clear accumulators and latch mode |
| mode_sel | input | 2 | Compaction method code (0 ones, 1 transitions, 2 parity, 3 signature register) |
| bit_valid | input | 1 | Qualifies bit_in |
| bit_in | input | 1 | Serial response bit |
| signature | output | CNT_W | Compacted result for the latched mode |
| vec_count | output | CNT_W | Number of accepted bits |
| ready | output | 1 | A run is active since a start pulse |
| overflow | output | 1 | Sticky saturation flag |

## Verification
Every accepted bit updates the signature and vec_count at the rising edge where it is sampled, so both results are due one edge after the bit. The ready flag and the cleared state are likewise due one edge after start. The bench drives inputs on the falling edge and reads outputs on the falling edge after the capturing rising edge. The overflow check therefore reads the flag after the 256th accepted one, the first increment that arrives at the maximum.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

    typedef enum logic [1:0] {
        MODE_ONES   = 2'd0,
        MODE_TRANS  = 2'd1,
        MODE_PARITY = 2'd2,
        MODE_SISR   = 2'd3
    } cmp_mode_e;

    localparam int SISR_W = 3;

    typedef logic [SISR_W-1:0] sisr_t;

    // one step of the serial-input signature register
    function automatic sisr_t sisr_step(sisr_t s, logic b);
        return {s[SISR_W-2:0], s[SISR_W-1] ^ s[SISR_W-2] ^ b};
    endfunction

endpackage

// File: rtl/cmp_sat_counter.sv
module cmp_sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count,
    output logic         ovf
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
            ovf   <= 1'b0;
        end else if (inc) begin
            if (count == MAXV) ovf <= 1'b1;
            else               count <= count + 1'b1;
        end
    end

    // R8: saturated value holds under further increments
    assert_sat_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (count == MAXV && inc && !clr) |=> (count == MAXV && ovf));

    // R8: overflow is sticky until cleared
    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (ovf && !clr) |=> ovf);

    // R10: no increment, no change
    assert_idle_stable_R10: assert property (@(posedge clk) disable iff (rst)
        (!inc && !clr) |=> $stable(count));
endmodule

// File: rtl/cmp_edge_track.sv
module cmp_edge_track (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic take,
    input  logic din,
    output logic change
);
    logic prev_q;
    logic have_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            prev_q <= 1'b0;
            have_q <= 1'b0;
        end else if (take) begin
            prev_q <= din;
            have_q <= 1'b1;
        end
    end

    assign change = take && have_q && (din ^ prev_q);

    // R4: first bit after a clear never counts as a change
    assert_first_no_change_R4: assert property (@(posedge clk) disable iff (rst)
        clr |=> !change);
endmodule

// File: rtl/cmp_sisr.sv
module cmp_sisr
    import cmp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  take,
    input  logic  din,
    output sisr_t state
);
    always_ff @(posedge clk) begin
        if (rst || clr)  state <= '0;
        else if (take)   state <= sisr_step(state, din);
    end

    // R6: state is held when no bit is accepted
    assert_sisr_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!take && !clr) |=> $stable(state));
endmodule

// File: rtl/resp_compactor.sv
module resp_compactor
    import cmp_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [1:0]       mode_sel,
    input  logic             bit_valid,
    input  logic             bit_in,
    output logic [CNT_W-1:0] signature,
    output logic [CNT_W-1:0] vec_count,
    output logic             ready,
    output logic             overflow
);
    localparam int PAD_W = CNT_W - SISR_W;

    cmp_mode_e        act_mode_q;
    logic             ready_q;
    logic             accept;
    logic             change;
    logic             main_inc;
    logic [CNT_W-1:0] main_cnt;
    logic             main_ovf;
    logic             vec_ovf;
    logic             parity_q;
    sisr_t            sisr_state;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_mode_q <= MODE_ONES;
            ready_q    <= 1'b0;
        end else if (start) begin
            act_mode_q <= cmp_mode_e'(mode_sel);
            ready_q    <= 1'b1;
        end
    end

    assign accept = bit_valid && ready_q && !start;

    cmp_edge_track u_edge (
        .clk(clk), .rst(rst), .clr(start),
        .take(accept), .din(bit_in), .change(change)
    );

    always_comb begin
        unique case (act_mode_q)
            MODE_ONES:  main_inc = accept && bit_in;
            MODE_TRANS: main_inc = change;
            default:    main_inc = 1'b0;
        endcase
    end

    cmp_sat_counter #(.W(CNT_W)) u_main (
        .clk(clk), .rst(rst), .clr(start),
        .inc(main_inc), .count(main_cnt), .ovf(main_ovf)
    );

    cmp_sat_counter #(.W(CNT_W)) u_vec (
        .clk(clk), .rst(rst), .clr(start),
        .inc(accept), .count(vec_count), .ovf(vec_ovf)
    );

    always_ff @(posedge clk) begin
        if (rst || start)          parity_q <= 1'b0;
        else if (accept && bit_in) parity_q <= ~parity_q;
    end

    cmp_sisr u_sisr (
        .clk(clk), .rst(rst), .clr(start),
        .take(accept), .din(bit_in), .state(sisr_state)
    );

    always_comb begin
        unique case (act_mode_q)
            MODE_ONES, MODE_TRANS: signature = main_cnt;
            MODE_PARITY:           signature = {{(CNT_W-1){1'b0}}, parity_q};
            default:               signature = {{PAD_W{1'b0}}, sisr_state};
        endcase
    end

    assign ready    = ready_q;
    assign overflow = main_ovf || vec_ovf;

    // R2: start clears results and arms the block
    assert_start_clears_R2: assert property (@(posedge clk) disable iff (rst)
        start |=> (signature == '0 && vec_count == '0 && ready && !overflow));

    // R1: nothing accepted before the first start
    assert_idle_before_start_R1: assert property (@(posedge clk) disable iff (rst)
        (!ready && !start) |=> (vec_count == '0));

    // R5: each accepted one flips parity
    assert_parity_flip_R5: assert property (@(posedge clk) disable iff (rst)
        (act_mode_q == MODE_PARITY && accept && bit_in) |=>
            (signature[0] != $past(signature[0])));

    // R10: invalid cycles leave results unchanged
    assert_invalid_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (!bit_valid && !start) |=> ($stable(signature) && $stable(vec_count)));

    // R9: mode only moves on start
    assert_mode_latched_R9: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(act_mode_q));
endmodule

// File: tb/resp_compactor_test.sv
`timescale 1ns/1ps
module resp_compactor_test;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst;
    logic             start;
    logic [1:0]       mode_sel;
    logic             bit_valid;
    logic             bit_in;
    logic [CNT_W-1:0] signature;
    logic [CNT_W-1:0] vec_count;
    logic             ready;
    logic             overflow;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    resp_compactor #(.CNT_W(CNT_W)) uut (
        .clk(clk), .rst(rst), .start(start), .mode_sel(mode_sel),
        .bit_valid(bit_valid), .bit_in(bit_in), .signature(signature),
        .vec_count(vec_count), .ready(ready), .overflow(overflow)
    );

    typedef struct packed {
        logic [1:0] mode;
        logic [3:0] len;
        logic [7:0] pat;   // bit i is sent i-th
        logic [7:0] sig;
        logic [7:0] vec;
    } tvec_t;

    localparam int NV = 10;
    localparam tvec_t TBL [NV] = '{
        '{2'd0, 4'd8, 8'hB6, 8'd5, 8'd8},  // R3 ones
        '{2'd0, 4'd4, 8'h0F, 8'd4, 8'd4},  // R3 all ones
        '{2'd1, 4'd8, 8'hB6, 8'd5, 8'd8},  // R4 mixed
        '{2'd1, 4'd2, 8'h02, 8'd1, 8'd2},  // R4 rising
        '{2'd1, 4'd2, 8'h01, 8'd1, 8'd2},  // R4 falling aliases rising
        '{2'd1, 4'd1, 8'h01, 8'd0, 8'd1},  // R4 first bit
        '{2'd2, 4'd8, 8'hB6, 8'd1, 8'd8},  // R5 odd
        '{2'd2, 4'd6, 8'h33, 8'd0, 8'd6},  // R5 even
        '{2'd3, 4'd4, 8'h0B, 8'd7, 8'd4},  // R6
        '{2'd3, 4'd3, 8'h01, 8'd5, 8'd3}   // R6
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_start(input logic [1:0] m);
        @(negedge clk);
        start = 1'b1; mode_sel = m; bit_valid = 1'b0;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic send(input logic b);
        bit_valid = 1'b1; bit_in = b;
        @(negedge clk);
        bit_valid = 1'b0;
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; mode_sel = 2'd0; bit_valid = 1'b0; bit_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 sig", int'(signature), 0);
        check("R1 vec", int'(vec_count), 0);
        check("R1 ready", int'(ready), 0);
        check("R1 ovf", int'(overflow), 0);
        send(1'b1); send(1'b1);
        check("R1 ignored before start", int'(vec_count), 0);

        for (int i = 0; i < NV; i++) begin
            pulse_start(TBL[i].mode);
            for (int k = 0; k < int'(TBL[i].len); k++) send(TBL[i].pat[k]);
            check($sformatf("R3-6 table %0d sig", i), int'(signature), int'(TBL[i].sig));
            check($sformatf("R7 table %0d vec", i), int'(vec_count), int'(TBL[i].vec));
        end

        // R2: bit with start dropped, ready set
        @(negedge clk);
        start = 1'b1; mode_sel = 2'd0; bit_valid = 1'b1; bit_in = 1'b1;
        @(negedge clk);
        start = 1'b0; bit_valid = 1'b0;
        check("R2 vec", int'(vec_count), 0);
        check("R2 sig", int'(signature), 0);
        check("R2 ready", int'(ready), 1);

        // R10: invalid bits ignored
        bit_in = 1'b1;
        repeat (4) @(negedge clk);
        check("R10 sig", int'(signature), 0);
        check("R10 vec", int'(vec_count), 0);

        // R9: mode change mid-run ignored
        send(1'b1);
        mode_sel = 2'd2;
        send(1'b1); send(1'b1);
        check("R9 sig", int'(signature), 3);

        // R8: saturation and sticky overflow
        pulse_start(2'd0);
        for (int k = 0; k < 255; k++) send(1'b1);
        check("R8 sig at max", int'(signature), 255);
        check("R8 ovf clear at max", int'(overflow), 0);
        send(1'b1);
        check("R8 sig saturated", int'(signature), 255);
        check("R8 vec saturated", int'(vec_count), 255);
        check("R8 ovf set", int'(overflow), 1);
        send(1'b0);
        check("R8 ovf sticky", int'(overflow), 1);
        pulse_start(2'd0);
        check("R8 ovf cleared by start", int'(overflow), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule